// File: doc/BRIEF.md
# Wide Timestamp Extender

This block sits behind a timestamp event queue whose hardware counter is only 32 bits wide. It receives every drained event (a 3-bit kind plus the 32-bit counter value captured with it) and tracks how many times the counter has wrapped, so each capture event is reported as a 64-bit time in nanoseconds. The wide count is multiplied by an integer nanoseconds-per-tick factor, taken from a static input once after reset.

Wrap tracking uses two event kinds the counter emits by itself: a full wrap, which bumps the stored epoch, and a half-way mark, which tells the block that later captures can no longer predate the last wrap. A capture read after a wrap event but taken just before it (counter MSB still set while the block believes the counter is in its first half) is credited to the previous epoch.

The block also serves one time request at a time. A set request converts nanoseconds to ticks with a serial divider, loads the low 32 bits into the counter and keeps the upper bits as the epoch. A get request pulses a push command and waits a bounded number of cycles for the push event. An adjust request performs a get, adds a signed offset to the result and writes it back as a set.

Top module: `tsx_wide_clock`

## Requirements
- R1: After reset, ts_valid_o, push_o, load_o and rsp_valid_o are low and req_ready_o is high.
- R2: An event of kind 0 (push), 3 (external capture), 4 (receive) or 5 (transmit) yields ts_valid_o for one cycle in the cycle after it is presented, with ts_type_o equal to its kind and ts_ns_o = {epoch, low count} times the factor, truncated to 64 bits; kinds 1, 2, 6 and 7 yield no output.
- R3: A kind 1 event (counter wrap) increments the epoch by one and sets the first-half flag.
- R4: A kind 2 event (half-way mark) clears the first-half flag.
- R5: While the first-half flag is set, a capture whose low count has bit 31 set uses epoch minus one; otherwise the current epoch is used.
- R6: The factor is taken from tick_ns_i on the first clock after reset; later changes of tick_ns_i have no effect.
- R7: A set request (req_op_i = 1) divides req_ns_i by the factor; load_o pulses with load_val_o equal to the quotient's low 32 bits, the quotient's upper bits become the epoch, and rsp_valid_o pulses in the same cycle with rsp_busy_o low and rsp_ns_o zero.
- R8: A get request (req_op_i = 0 or 3) pulses push_o for one cycle; the next push event makes rsp_valid_o pulse with rsp_busy_o low and rsp_ns_o equal to that event's time, which also appears on the ts_* outputs.
- R9: If no push event arrives within WAIT_CYC cycles after push_o, rsp_valid_o pulses with rsp_busy_o high and rsp_ns_o zero, and no load is issued.
- R10: An adjust request (req_op_i = 2) takes the push-event time, adds req_ns_i as a signed 64-bit offset, and completes as a set of that sum.
- R11: req_ready_o is low while a request is in progress and requests presented then are ignored; events arriving meanwhile still update the epoch and flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_ns_i | input | FAC_W | Nanoseconds per counter tick, static |
| evt_valid_i | input | 1 | Event present this cycle |
| evt_type_i | input | 3 | Event kind |
| evt_low_i | input | CNT_W | Counter value captured with the event |
| ts_valid_o | output | 1 | Extended capture time valid |
| ts_type_o | output | 3 | Kind of the reported capture |
| ts_ns_o | output | CNT_W+EPOCH_W | Capture time in nanoseconds |
| req_valid_i | input | 1 | Time request present |
| req_ready_o | output | 1 | Block idle, request accepted |
| req_op_i | input | 2 | 0 get, 1 set, 2 adjust, 3 get |
| req_ns_i | input | CNT_W+EPOCH_W | Set time or signed adjust offset |
| push_o | output | 1 | Counter push command |
| load_o | output | 1 | Counter load command |
| load_val_o | output | CNT_W | Value to load into the counter |
| rsp_valid_o | output | 1 | Request completed |
| rsp_busy_o | output | 1 | Get timed out |
| rsp_ns_o | output | CNT_W+EPOCH_W | Time read by a get, else zero |

## Verification
A wrong epoch or first-half flag does not show until the next capture event, and then as a time off by exactly one wrap period times the factor, so the bench brackets every wrap and half-way mark with captures whose counter MSB is both set and clear. A lost or stuck request state shows as a missing, duplicated or early response, or a held-low ready, within WAIT_CYC cycles or one division of 64 steps; the scoreboard flags any response or load it did not expect. A bad quotient shows directly on load_val_o and one capture later through the epoch.

// File: rtl/tsx_pkg.sv
package tsx_pkg;
  typedef enum logic [2:0] {
    EV_PUSH  = 3'd0,
    EV_WRAP  = 3'd1,
    EV_HALF  = 3'd2,
    EV_EXTC  = 3'd3,
    EV_RX    = 3'd4,
    EV_TX    = 3'd5
  } ev_e;

  typedef enum logic [1:0] {
    OP_GET = 2'd0,
    OP_SET = 2'd1,
    OP_ADJ = 2'd2
  } op_e;

  function automatic logic is_capture(logic [2:0] k);
    return (k == EV_PUSH) || (k == EV_EXTC) || (k == EV_RX) || (k == EV_TX);
  endfunction
endpackage

// File: rtl/tsx_epoch.sv
module tsx_epoch
  import tsx_pkg::*;
#(
  parameter int CW = 32,
  parameter int EW = 32,
  parameter int FW = 8,
  localparam int TW = CW + EW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [FW-1:0] fac_i,
  input  logic          evt_valid_i,
  input  logic [2:0]    evt_type_i,
  input  logic [CW-1:0] evt_low_i,
  input  logic          epoch_ld_i,
  input  logic [EW-1:0] epoch_val_i,
  output logic          cap_valid_o,
  output logic [2:0]    cap_type_o,
  output logic [TW-1:0] cap_ns_o
);
  logic [EW-1:0] epoch_q;
  logic          first_half_q;
  logic [EW-1:0] hi_sel;
  logic [TW-1:0] wide;

  // capture taken before a wrap but read after it
  always_comb begin
    hi_sel = (first_half_q && evt_low_i[CW-1]) ? epoch_q - 1'b1 : epoch_q;
    wide   = {hi_sel, evt_low_i};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      epoch_q      <= '0;
      first_half_q <= 1'b0;
      cap_valid_o  <= 1'b0;
      cap_type_o   <= '0;
      cap_ns_o     <= '0;
    end else begin
      cap_valid_o <= evt_valid_i && is_capture(evt_type_i);
      if (evt_valid_i && is_capture(evt_type_i)) begin
        cap_type_o <= evt_type_i;
        cap_ns_o   <= wide * TW'(fac_i);
      end
      if (evt_valid_i && evt_type_i == EV_WRAP) first_half_q <= 1'b1;
      else if (evt_valid_i && evt_type_i == EV_HALF) first_half_q <= 1'b0;
      // a load from the request side wins over a same-cycle wrap
      if (epoch_ld_i) epoch_q <= epoch_val_i;
      else if (evt_valid_i && evt_type_i == EV_WRAP) epoch_q <= epoch_q + 1'b1;
    end
  end

  p_wrap_inc_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_valid_i && evt_type_i == EV_WRAP && !epoch_ld_i)
      |=> (epoch_q == $past(epoch_q) + 1'b1) && first_half_q);

  p_half_clr_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_valid_i && evt_type_i == EV_HALF) |=> !first_half_q);

  p_noncap_quiet_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_valid_i && !is_capture(evt_type_i)) |=> !cap_valid_o);
endmodule

// File: rtl/tsx_div.sv
module tsx_div #(
  parameter int NW = 64,
  parameter int DW = 8,
  localparam int KW = $clog2(NW)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [NW-1:0] dvd_i,
  input  logic [DW-1:0] dvs_i,
  output logic          busy_o,
  output logic          done_o,
  output logic [NW-1:0] quo_o
);
  logic [DW-1:0] rem_q, dvs_q;
  logic [KW-1:0] cnt_q;
  logic [DW:0]   sh, diff;
  logic          ge;

  always_comb begin
    sh   = {rem_q, quo_o[NW-1]};
    diff = sh - {1'b0, dvs_q};
    ge   = sh >= {1'b0, dvs_q};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rem_q  <= '0;
      dvs_q  <= '0;
      cnt_q  <= '0;
      busy_o <= 1'b0;
      done_o <= 1'b0;
      quo_o  <= '0;
    end else begin
      done_o <= 1'b0;
      if (start_i) begin
        rem_q  <= '0;
        dvs_q  <= dvs_i;
        quo_o  <= dvd_i;
        cnt_q  <= '0;
        busy_o <= 1'b1;
      end else if (busy_o) begin
        rem_q <= ge ? diff[DW-1:0] : sh[DW-1:0];
        quo_o <= {quo_o[NW-2:0], ge};
        cnt_q <= cnt_q + 1'b1;
        if (cnt_q == KW'(NW - 1)) begin
          busy_o <= 1'b0;
          done_o <= 1'b1;
        end
      end
    end
  end

  p_start_idle_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> !busy_o);

  p_done_pulse_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o && !busy_o);
endmodule

// File: rtl/tsx_req_ctrl.sv
module tsx_req_ctrl
  import tsx_pkg::*;
#(
  parameter int TW       = 64,
  parameter int CW       = 32,
  parameter int WAIT_CYC = 20,
  localparam int KW = $clog2(WAIT_CYC + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  input  logic [1:0]       req_op_i,
  input  logic [TW-1:0]    req_ns_i,
  output logic             req_ready_o,
  input  logic             cap_valid_i,
  input  logic [2:0]       cap_type_i,
  input  logic [TW-1:0]    cap_ns_i,
  output logic             div_start_o,
  output logic [TW-1:0]    div_dvd_o,
  input  logic             div_done_i,
  input  logic [TW-1:0]    div_quo_i,
  output logic             push_o,
  output logic             load_o,
  output logic [CW-1:0]    load_val_o,
  output logic             epoch_ld_o,
  output logic [TW-CW-1:0] epoch_val_o,
  output logic             rsp_valid_o,
  output logic             rsp_busy_o,
  output logic [TW-1:0]    rsp_ns_o
);
  typedef enum logic [1:0] {S_IDLE, S_WAIT, S_DSTART, S_DIV} st_e;

  st_e           st_q;
  logic          is_adj_q;
  logic [TW-1:0] arg_q;
  logic [KW-1:0] cnt_q;
  logic          push_hit;

  assign push_hit    = cap_valid_i && cap_type_i == EV_PUSH;
  assign req_ready_o = st_q == S_IDLE;
  assign div_start_o = st_q == S_DSTART;
  assign div_dvd_o   = arg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q        <= S_IDLE;
      is_adj_q    <= 1'b0;
      arg_q       <= '0;
      cnt_q       <= '0;
      push_o      <= 1'b0;
      load_o      <= 1'b0;
      load_val_o  <= '0;
      epoch_ld_o  <= 1'b0;
      epoch_val_o <= '0;
      rsp_valid_o <= 1'b0;
      rsp_busy_o  <= 1'b0;
      rsp_ns_o    <= '0;
    end else begin
      push_o      <= 1'b0;
      load_o      <= 1'b0;
      epoch_ld_o  <= 1'b0;
      rsp_valid_o <= 1'b0;
      unique case (st_q)
        S_IDLE: if (req_valid_i) begin
          arg_q <= req_ns_i;
          if (req_op_i == OP_SET) begin
            st_q <= S_DSTART;
          end else begin
            is_adj_q <= req_op_i == OP_ADJ;
            push_o   <= 1'b1;
            cnt_q    <= '0;
            st_q     <= S_WAIT;
          end
        end
        S_WAIT: begin
          if (push_hit) begin
            if (is_adj_q) begin
              arg_q <= cap_ns_i + arg_q;
              st_q  <= S_DSTART;
            end else begin
              rsp_valid_o <= 1'b1;
              rsp_busy_o  <= 1'b0;
              rsp_ns_o    <= cap_ns_i;
              st_q        <= S_IDLE;
            end
          end else if (cnt_q == KW'(WAIT_CYC - 1)) begin
            rsp_valid_o <= 1'b1;
            rsp_busy_o  <= 1'b1;
            rsp_ns_o    <= '0;
            st_q        <= S_IDLE;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        S_DSTART: st_q <= S_DIV;
        S_DIV: if (div_done_i) begin
          load_o      <= 1'b1;
          load_val_o  <= div_quo_i[CW-1:0];
          epoch_ld_o  <= 1'b1;
          epoch_val_o <= div_quo_i[TW-1:CW];
          rsp_valid_o <= 1'b1;
          rsp_busy_o  <= 1'b0;
          rsp_ns_o    <= '0;
          st_q        <= S_IDLE;
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  p_push_pulse_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_o |=> !push_o);

  p_busy_no_load_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && rsp_busy_o) |-> (rsp_ns_o == '0) && !load_o);

  p_wait_bound_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == S_WAIT) |-> (cnt_q < KW'(WAIT_CYC)));

  p_load_with_rsp_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_o |-> rsp_valid_o && !rsp_busy_o && epoch_ld_o);

  p_busy_ignores_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !req_ready_o) |=> !push_o);
endmodule

// File: rtl/tsx_wide_clock.sv
module tsx_wide_clock #(
  parameter int CNT_W    = 32,
  parameter int EPOCH_W  = 32,
  parameter int FAC_W    = 8,
  parameter int WAIT_CYC = 20,
  localparam int TW = CNT_W + EPOCH_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [FAC_W-1:0] tick_ns_i,
  input  logic             evt_valid_i,
  input  logic [2:0]       evt_type_i,
  input  logic [CNT_W-1:0] evt_low_i,
  output logic             ts_valid_o,
  output logic [2:0]       ts_type_o,
  output logic [TW-1:0]    ts_ns_o,
  input  logic             req_valid_i,
  output logic             req_ready_o,
  input  logic [1:0]       req_op_i,
  input  logic [TW-1:0]    req_ns_i,
  output logic             push_o,
  output logic             load_o,
  output logic [CNT_W-1:0] load_val_o,
  output logic             rsp_valid_o,
  output logic             rsp_busy_o,
  output logic [TW-1:0]    rsp_ns_o
);
  logic [FAC_W-1:0]   fac_q;
  logic               fac_ld_q;
  logic               epoch_ld;
  logic [EPOCH_W-1:0] epoch_val;
  logic               div_start, div_busy, div_done;
  logic [TW-1:0]      div_dvd, div_quo;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fac_q    <= '0;
      fac_ld_q <= 1'b0;
    end else if (!fac_ld_q) begin
      fac_q    <= tick_ns_i;
      fac_ld_q <= 1'b1;
    end
  end

  tsx_epoch #(.CW(CNT_W), .EW(EPOCH_W), .FW(FAC_W)) u_epoch (
    .clk_i, .rst_ni,
    .fac_i       (fac_q),
    .evt_valid_i, .evt_type_i, .evt_low_i,
    .epoch_ld_i  (epoch_ld),
    .epoch_val_i (epoch_val),
    .cap_valid_o (ts_valid_o),
    .cap_type_o  (ts_type_o),
    .cap_ns_o    (ts_ns_o)
  );

  tsx_req_ctrl #(.TW(TW), .CW(CNT_W), .WAIT_CYC(WAIT_CYC)) u_ctrl (
    .clk_i, .rst_ni,
    .req_valid_i, .req_op_i, .req_ns_i, .req_ready_o,
    .cap_valid_i (ts_valid_o),
    .cap_type_i  (ts_type_o),
    .cap_ns_i    (ts_ns_o),
    .div_start_o (div_start),
    .div_dvd_o   (div_dvd),
    .div_done_i  (div_done),
    .div_quo_i   (div_quo),
    .push_o, .load_o, .load_val_o,
    .epoch_ld_o  (epoch_ld),
    .epoch_val_o (epoch_val),
    .rsp_valid_o, .rsp_busy_o, .rsp_ns_o
  );

  tsx_div #(.NW(TW), .DW(FAC_W)) u_div (
    .clk_i, .rst_ni,
    .start_i (div_start),
    .dvd_i   (div_dvd),
    .dvs_i   (fac_q),
    .busy_o  (div_busy),
    .done_o  (div_done),
    .quo_o   (div_quo)
  );

  p_fac_static_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fac_ld_q && $past(fac_ld_q)) |-> $stable(fac_q));

  p_div_only_busy_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    div_busy |-> !req_ready_o);
endmodule

// File: tb/tsx_wide_clock_bench.sv
module tsx_wide_clock_bench;
  localparam int FW = 8;
  localparam int WC = 20;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [FW-1:0] tick_ns = 8'd8;
  logic        evt_valid = 1'b0;
  logic [2:0]  evt_type = '0;
  logic [31:0] evt_low = '0;
  logic        ts_valid;
  logic [2:0]  ts_type;
  logic [63:0] ts_ns;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [1:0]  req_op = '0;
  logic [63:0] req_ns = '0;
  logic        push, load;
  logic [31:0] load_val;
  logic        rsp_valid, rsp_busy;
  logic [63:0] rsp_ns;

  always #2 clk = ~clk;

  tsx_wide_clock #(.FAC_W(FW), .WAIT_CYC(WC)) u_tsx_wide_clock (
    .clk_i(clk), .rst_ni(rst_n), .tick_ns_i(tick_ns),
    .evt_valid_i(evt_valid), .evt_type_i(evt_type), .evt_low_i(evt_low),
    .ts_valid_o(ts_valid), .ts_type_o(ts_type), .ts_ns_o(ts_ns),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_op_i(req_op),
    .req_ns_i(req_ns), .push_o(push), .load_o(load), .load_val_o(load_val),
    .rsp_valid_o(rsp_valid), .rsp_busy_o(rsp_busy), .rsp_ns_o(rsp_ns)
  );

  int n_vec = 0;
  int n_err = 0;
  logic [66:0] ts_exp[$];
  logic [64:0] rsp_exp[$];
  logic [31:0] load_exp[$];
  logic [31:0] ep_m = '0;
  bit          fh_m = 1'b0;
  longint unsigned fac_m = 8;

  task automatic chk(string tag, logic [127:0] act, logic [127:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] cap_exp(logic [31:0] low);
    logic [31:0] hi;
    hi = (fh_m && low[31]) ? ep_m - 1 : ep_m;
    return {hi, low} * fac_m;
  endfunction

  // scoreboard monitor
  always @(negedge clk) if (rst_n) begin
    if (ts_valid) begin
      if (ts_exp.size() == 0) chk("R2 unexpected ts", {ts_type, ts_ns}, '0);
      else chk("R2 ts", {ts_type, ts_ns}, ts_exp.pop_front());
    end
    if (rsp_valid) begin
      if (rsp_exp.size() == 0) chk("R8 unexpected rsp", {rsp_busy, rsp_ns}, '0);
      else chk("R8 rsp", {rsp_busy, rsp_ns}, rsp_exp.pop_front());
    end
    if (load) begin
      if (load_exp.size() == 0) chk("R7 unexpected load", load_val, '0);
      else chk("R7 load", load_val, load_exp.pop_front());
    end
  end

  task automatic send_evt(int k, logic [31:0] low);
    evt_valid = 1'b1;
    evt_type  = k[2:0];
    evt_low   = low;
    if (k == 0 || k == 3 || k == 4 || k == 5) ts_exp.push_back({k[2:0], cap_exp(low)});
    if (k == 1) begin ep_m = ep_m + 1; fh_m = 1'b1; end
    if (k == 2) fh_m = 1'b0;
    @(negedge clk);
    evt_valid = 1'b0;
  endtask

  task automatic do_req(logic [1:0] op, logic [63:0] ns);
    req_valid = 1'b1;
    req_op    = op;
    req_ns    = ns;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 200 && !req_ready; i++) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic wait_push();
    for (int i = 0; i < 10 && !push; i++) @(negedge clk);
    chk("R8 push issued", push, 1'b1);
  endtask

  task automatic set_time(logic [63:0] ns);
    logic [63:0] q;
    q = ns / fac_m;
    load_exp.push_back(q[31:0]);
    rsp_exp.push_back({1'b0, 64'd0});
    do_req(2'd1, ns);
    wait_idle();
    ep_m = q[63:32];
  endtask

  task automatic get_time(logic [31:0] low, bit wrap_first, logic [1:0] op);
    do_req(op, '0);
    wait_push();
    if (wrap_first) begin
      chk("R11 ready low during get", req_ready, 1'b0);
      req_valid = 1'b1; req_op = 2'd1; req_ns = 64'd999;  // ignored
      send_evt(1, 32'h0);
      req_valid = 1'b0;
    end
    rsp_exp.push_back({1'b0, cap_exp(low)});
    send_evt(0, low);
    wait_idle();
  endtask

  task automatic adjust(logic [31:0] low, logic [63:0] delta);
    logic [63:0] q;
    do_req(2'd2, delta);
    wait_push();
    q = (cap_exp(low) + delta) / fac_m;
    load_exp.push_back(q[31:0]);
    rsp_exp.push_back({1'b0, 64'd0});
    send_evt(0, low);
    wait_idle();
    ep_m = q[63:32];
  endtask

  initial begin
    #(200000 * 4);
    n_err++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    chk("R1 ts_valid", ts_valid, 1'b0);
    chk("R1 push", push, 1'b0);
    chk("R1 load", load, 1'b0);
    chk("R1 rsp_valid", rsp_valid, 1'b0);
    chk("R1 ready", req_ready, 1'b1);

    // R2: capture kinds with epoch 0
    send_evt(4, 32'd100);
    send_evt(5, 32'hFFFF_FFFF);
    @(negedge clk);

    // R7: set epoch 5, counter 10
    set_time((64'd5 << 32) * 8 + 64'd80);

    // R3 + R5: wrap then captures with MSB set and clear
    send_evt(1, 32'h0);
    send_evt(4, 32'h8000_0010);
    send_evt(5, 32'h0000_0010);
    // R4: half-way mark, MSB-set capture now uses current epoch
    send_evt(2, 32'h8000_0000);
    send_evt(4, 32'h8000_0020);

    // R2: kinds 6 and 7 ignored, no output, epoch untouched
    send_evt(6, 32'h1);
    send_evt(7, 32'h2);
    chk("R2 no output for kind 7", ts_valid, 1'b0);
    @(negedge clk);

    // R6: factor change after reset has no effect (model keeps 8)
    tick_ns = 8'd3;
    @(negedge clk);
    send_evt(3, 32'h30);
    @(negedge clk);

    // R8: plain get, and op 3 treated as get
    get_time(32'h1234, 1'b0, 2'd0);
    get_time(32'h5678, 1'b0, 2'd3);
    // R11: wrap during get, ignored request while busy
    get_time(32'h8000_0001, 1'b1, 2'd0);

    // R9: timeout
    rsp_exp.push_back({1'b1, 64'd0});
    do_req(2'd0, '0);
    wait_push();
    wait_idle();

    // R10: adjust back and forward
    adjust(32'h200, -64'sd800);
    send_evt(4, 32'h40);
    adjust(32'h7FFF_FFF0, 64'd1_000_000_000);
    send_evt(5, 32'h8000_0040);
    send_evt(2, 32'h0);
    send_evt(5, 32'h8000_0040);

    // R7: set with a value not a multiple of the factor
    set_time(64'd12345);
    send_evt(4, 32'd7);
    send_evt(1, 32'h0);
    send_evt(4, 32'hFFFF_FFFF);

    repeat (5) @(negedge clk);
    chk("R2 ts queue drained", ts_exp.size(), 0);
    chk("R8 rsp queue drained", rsp_exp.size(), 0);
    chk("R7 load queue drained", load_exp.size(), 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
    $finish;
  end
endmodule